// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block watches an embedded flash device after a program or erase command has already been issued, and decides when the operation has finished and whether it worked. It reads the same location twice in a row, and keeps doing so while data bit 6 keeps changing between the two reads. The data bus carries a parameterised number of interleaved 8-bit devices. Each byte lane has its own busy bit (bit 6) and its own internal-timeout bit (bit 5).

Once bit 6 stops changing, or the cycle timer passes the limit given at start, the block takes two more reads. Both must equal the expected word for a pass; an erase passes all ones as that word. On failure it tells a device-side timeout apart from a controller-side timeout. It does so by looking at bit 5 only in lanes whose bit 6 still toggled in the last pair. It also keeps the last four words read, for debug. A programmable gap, in clocks, separates successive poll pairs.

Top module: `toggle_poll_engine`

## Requirements
- R1: After reset the outputs `busy`, `rdReq` and `doneOut` are 0 and `resultOut` is 0. A `startIn` pulse while idle captures `expectIn`, `limitIn` and `gapIn` and raises `busy`. A `startIn` while busy is ignored and does not change the outcome.
- R2: Every read is a one-cycle `rdReq` pulse, and at most one read is outstanding. The next request comes only after `rdValid`. The first request follows one cycle after `startIn` is sampled. Within a pair, the second request follows one cycle after the first read's `rdValid`.
- R3: A poll pair is "toggling" when bit 6 of any byte lane differs between its two reads (lane l occupies bits 8l+7..8l). The cycle timer counts from start and saturates. It has expired when its count is at least the captured limit, so a limit of 0 is expired at once. Polling repeats while a pair toggles and the timer has not expired. Bit 5 plays no part in this decision.
- R4: After a toggling pair that does not stop the loop, the next pair's first request is issued gap+2 cycles after the cycle in which the second read's `rdValid` was high. When the loop stops, the first of the two closing reads is issued 2 cycles after that `rdValid`.
- R5: After the loop stops, exactly two more reads are taken. The result is pass (code 0) only if both equal the captured expected word.
- R6: If the loop stopped with a toggling pair and an expired timer, and the closing reads do not both match, the lane mask is the set of lanes whose bit 6 differs between the two closing reads. `laneTmoOut[l]` is set when lane l is in the mask and bit 5 of lane l is set in the last read. The result is device timeout (code 1) if any lane flag is set.
- R7: In the case of R6 with no lane flag set, the result is controller timeout (code 2) and `laneTmoOut` is 0. A set bit 5 in a lane that is not toggling is ignored.
- R8: If the closing reads do not both match and the loop did not stop on timeout, the result is undecodable (code 3) and `laneTmoOut` is 0. One mismatching closing read suffices.
- R9: `doneOut` is a one-cycle pulse, high 2 cycles after the cycle in which the last closing read's `rdValid` was high. `busy` is low from that cycle on. `resultOut`, `laneTmoOut` and `dbgWords` hold until the next completion.
- R10: `dbgWords` holds four words, lowest slice first: the last poll pair's first and second reads, then the first and second closing reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start pulse, taken only while idle |
| expectIn | input | 8*LANES | Word the device must return once finished |
| limitIn | input | TMR_W | Timeout limit in clock cycles |
| gapIn | input | GAP_W | Idle clocks between poll pairs |
| rdReq | output | 1 | One-cycle read request |
| rdData | input | 8*LANES | Returned read data |
| rdValid | input | 1 | Read data valid |
| busy | output | 1 | Operation in progress |
| doneOut | output | 1 | Completion pulse |
| resultOut | output | 2 | 0 pass, 1 device timeout, 2 controller timeout, 3 undecodable |
| laneTmoOut | output | LANES | Lanes that reported an internal timeout |
| dbgWords | output | 32*LANES | Last four read words, see R10 |

## Verification
Some properties are checked on every cycle by the assertions. Requests and completion strobes last one cycle, and data returns only while a read is awaited. Gap countdowns run for their full length, and the timer never runs backwards. A lane flag never appears without a device-timeout result, and a pass is never reported unless both closing words equal the expected word. Only the bench scenarios show the rest: the cycle-exact spacing of requests around gaps, the number of reads taken, that bit 5 is ignored while polling and masked on timeout, and the choice among the four outcomes for particular read patterns.

// File: rtl/toggle_poll_pkg.sv
package toggle_poll_pkg;

  typedef enum logic [1:0] {
    RES_PASS    = 2'd0,
    RES_DEV_TMO = 2'd1,
    RES_CTL_TMO = 2'd2,
    RES_UNKNOWN = 2'd3
  } pollResult_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic arm;        // capture operands, clear timer
    logic takeFirst;  // store first read of a pair
    logic takeSecond; // store second read of a pair
    logic keepHist;   // loop ends: save last poll pair, latch timeout flag
    logic finish;     // closing pair in: decode and register result
  } dpStrobe_t;

endpackage

// File: rtl/toggle_poll_dp.sv
module toggle_poll_dp
  import toggle_poll_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TMR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [8*LANES-1:0]   expectIn,
  input  logic [TMR_W-1:0]     limitIn,
  input  logic [8*LANES-1:0]   rdData,
  output logic                 toggleAny,
  output logic                 expired,
  output logic [1:0]           resultOut,
  output logic [LANES-1:0]     laneTmoOut,
  output logic [32*LANES-1:0]  dbgWords
);
  localparam int W       = 8 * LANES;
  localparam int BUSY_B  = 6;
  localparam int TMO_B   = 5;

  logic [W-1:0]     expReg, smpA, smpB, histA, histB;
  logic [TMR_W-1:0] limReg, timer;
  logic             tmoFlag;
  pollResult_t      resReg;
  logic [LANES-1:0] laneReg, laneToggle, laneHit;
  logic [4*W-1:0]   dbgReg;
  logic             bothMatch;

  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      assign laneToggle[l] = smpA[8*l+BUSY_B] ^ smpB[8*l+BUSY_B];
      assign laneHit[l]    = laneToggle[l] & smpB[8*l+TMO_B];
    end
  endgenerate

  assign toggleAny = |laneToggle;
  assign expired   = (timer >= limReg);
  assign bothMatch = (smpA == expReg) && (smpB == expReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expReg  <= '0;
      limReg  <= '0;
      timer   <= '0;
      tmoFlag <= 1'b0;
      smpA    <= '0;
      smpB    <= '0;
      histA   <= '0;
      histB   <= '0;
      resReg  <= RES_PASS;
      laneReg <= '0;
      dbgReg  <= '0;
    end else begin
      if (strb.arm) begin
        expReg  <= expectIn;
        limReg  <= limitIn;
        timer   <= '0;
        tmoFlag <= 1'b0;
      end else if (timer != {TMR_W{1'b1}}) begin
        timer <= timer + TMR_W'(1);
      end
      if (strb.takeFirst)  smpA <= rdData;
      if (strb.takeSecond) smpB <= rdData;
      if (strb.keepHist) begin
        histA   <= smpA;
        histB   <= smpB;
        tmoFlag <= toggleAny && expired;
      end
      if (strb.finish) begin
        dbgReg <= {smpB, smpA, histB, histA};
        if (bothMatch) begin
          resReg  <= RES_PASS;
          laneReg <= '0;
        end else if (tmoFlag) begin
          resReg  <= (|laneHit) ? RES_DEV_TMO : RES_CTL_TMO;
          laneReg <= laneHit;
        end else begin
          resReg  <= RES_UNKNOWN;
          laneReg <= '0;
        end
      end
    end
  end

  assign resultOut  = resReg;
  assign laneTmoOut = laneReg;
  assign dbgWords   = dbgReg;

  // R6: lane flags only accompany a device-timeout result
  p_flags_dev_r6: assert property (@(posedge clk) disable iff (!rstN)
    (laneReg != '0) |-> (resReg == RES_DEV_TMO));

  // R5: pass is reported only when both closing words equal the expected word
  p_pass_words_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> ((resReg == RES_PASS) ==
                     ((dbgReg[3*W-1:2*W] == expReg) && (dbgReg[4*W-1:3*W] == expReg))));

  // R3: timer never runs backwards between starts
  p_timer_mono_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.arm |=> (timer >= $past(timer)));

  // R8: without a timeout at loop exit no timeout result can appear
  p_no_tmo_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && !tmoFlag) |=> (resReg != RES_DEV_TMO && resReg != RES_CTL_TMO));

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import toggle_poll_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             rdValid,
  input  logic             toggleAny,
  input  logic             expired,
  input  logic [GAP_W-1:0] gapIn,
  output dpStrobe_t        strb,
  output logic             rdReq,
  output logic             busy,
  output logic             doneOut
);
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_WAIT, S_EVAL, S_GAP} ctrlState_t;

  ctrlState_t       state;
  logic             secondRd, finalPh, keepPolling, doneReg;
  logic [GAP_W-1:0] gapReg, gapCnt;

  assign keepPolling = toggleAny && !expired;

  always_comb begin
    strb            = '0;
    strb.arm        = (state == S_IDLE) && startIn;
    strb.takeFirst  = (state == S_WAIT) && rdValid && !secondRd;
    strb.takeSecond = (state == S_WAIT) && rdValid && secondRd;
    strb.keepHist   = (state == S_EVAL) && !finalPh && !keepPolling;
    strb.finish     = (state == S_EVAL) && finalPh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      secondRd <= 1'b0;
      finalPh  <= 1'b0;
      gapReg   <= '0;
      gapCnt   <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= strb.finish;
      case (state)
        S_IDLE: if (startIn) begin
          gapReg   <= gapIn;
          secondRd <= 1'b0;
          finalPh  <= 1'b0;
          state    <= S_REQ;
        end
        S_REQ:  state <= S_WAIT;
        S_WAIT: if (rdValid) begin
          secondRd <= !secondRd;
          state    <= secondRd ? S_EVAL : S_REQ;
        end
        S_EVAL: begin
          if (finalPh) begin
            state <= S_IDLE;
          end else if (keepPolling) begin
            if (gapReg == '0) begin
              state <= S_REQ;
            end else begin
              gapCnt <= gapReg;
              state  <= S_GAP;
            end
          end else begin
            finalPh <= 1'b1;
            state   <= S_REQ;
          end
        end
        S_GAP: begin
          if (gapCnt == GAP_W'(1)) state <= S_REQ;
          else                     gapCnt <= gapCnt - GAP_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign rdReq   = (state == S_REQ);
  assign busy    = (state != S_IDLE);
  assign doneOut = doneReg;

  // R2: requests are single-cycle pulses
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> !rdReq);

  // R2: data only returns while a read is awaited
  p_valid_waiting_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (state == S_WAIT));

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R4: the gap wait is not cut short
  p_gap_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_GAP && gapCnt > GAP_W'(1)) |=> (state == S_GAP && !rdReq));

endmodule

// File: rtl/toggle_poll_engine.sv
module toggle_poll_engine
  import toggle_poll_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TMR_W = 32,
  parameter int GAP_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic [8*LANES-1:0]  expectIn,
  input  logic [TMR_W-1:0]    limitIn,
  input  logic [GAP_W-1:0]    gapIn,
  output logic                rdReq,
  input  logic [8*LANES-1:0]  rdData,
  input  logic                rdValid,
  output logic                busy,
  output logic                doneOut,
  output logic [1:0]          resultOut,
  output logic [LANES-1:0]    laneTmoOut,
  output logic [32*LANES-1:0] dbgWords
);
  dpStrobe_t strb;
  logic      toggleAny, expired;

  toggle_poll_ctrl #(.GAP_W(GAP_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .rdValid   (rdValid),
    .toggleAny (toggleAny),
    .expired   (expired),
    .gapIn     (gapIn),
    .strb      (strb),
    .rdReq     (rdReq),
    .busy      (busy),
    .doneOut   (doneOut)
  );

  toggle_poll_dp #(.LANES(LANES), .TMR_W(TMR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .expectIn   (expectIn),
    .limitIn    (limitIn),
    .rdData     (rdData),
    .toggleAny  (toggleAny),
    .expired    (expired),
    .resultOut  (resultOut),
    .laneTmoOut (laneTmoOut),
    .dbgWords   (dbgWords)
  );

endmodule

// File: tb/tb_toggle_poll_engine.sv
module tb_toggle_poll_engine;
  localparam int LANES = 2;
  localparam int W     = 8 * LANES;
  localparam int TMR_W = 32;
  localparam int GAP_W = 8;
  localparam int BIG_LIMIT = 100000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rstN = 1'b0, startIn = 1'b0, rdValid = 1'b0;
  logic [W-1:0]     expectIn = '0, rdData = '0;
  logic [TMR_W-1:0] limitIn = '0;
  logic [GAP_W-1:0] gapIn = '0;
  logic             rdReq, busy, doneOut;
  logic [1:0]       resultOut;
  logic [LANES-1:0] laneTmoOut;
  logic [4*W-1:0]   dbgWords;

  toggle_poll_engine #(.LANES(LANES), .TMR_W(TMR_W), .GAP_W(GAP_W)) dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .expectIn(expectIn),
    .limitIn(limitIn), .gapIn(gapIn), .rdReq(rdReq), .rdData(rdData),
    .rdValid(rdValid), .busy(busy), .doneOut(doneOut), .resultOut(resultOut),
    .laneTmoOut(laneTmoOut), .dbgWords(dbgWords)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  // scenario description
  logic [W-1:0]     expW, settleW, ovrVal;
  int               busyReads, ovrIdx, limitV, gapV;
  logic [LANES-1:0] togL, b5L;
  // reference model results
  int               nReads;
  logic [1:0]       expRes;
  logic [LANES-1:0] expFlags;
  logic [W-1:0]     expDbg [4];
  // monitor state
  int readIdx, nextReqCyc, doneCyc, validIdx;
  bit pendValid = 0, doneSeen = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exv);
    end
  endtask

  function automatic logic [W-1:0] devWord(int k);
    logic [W-1:0] w;
    if (k == ovrIdx) return ovrVal;
    if (k >= busyReads) return settleW;
    for (int l = 0; l < LANES; l++)
      w[8*l +: 8] = 8'h11 | (b5L[l] ? 8'h20 : 8'h00) | ((togL[l] && (k % 2 == 1)) ? 8'h40 : 8'h00);
    return w;
  endfunction

  function automatic logic [LANES-1:0] togLanes(logic [W-1:0] a, logic [W-1:0] b);
    logic [LANES-1:0] t;
    for (int l = 0; l < LANES; l++) t[l] = a[8*l+6] ^ b[8*l+6];
    return t;
  endfunction

  task automatic buildModel();
    logic [W-1:0] a, b, fa, fb;
    logic [LANES-1:0] ft;
    bit tmo;
    int k = 0;
    tmo = 0;
    a = '0; b = '0;
    while (k < 2000) begin
      a = devWord(k); b = devWord(k + 1); k += 2;
      if (togLanes(a, b) != '0 && limitV != 0) continue;
      tmo = (togLanes(a, b) != '0) && (limitV == 0);
      break;
    end
    fa = devWord(k); fb = devWord(k + 1);
    nReads = k + 2;
    expDbg[0] = a; expDbg[1] = b; expDbg[2] = fa; expDbg[3] = fb;
    expFlags = '0;
    if (fa == expW && fb == expW) expRes = 2'd0;
    else if (tmo) begin
      ft = togLanes(fa, fb);
      for (int l = 0; l < LANES; l++) expFlags[l] = ft[l] & fb[8*l+5];
      expRes = (expFlags != '0) ? 2'd1 : 2'd2;
    end else expRes = 2'd3;
  endtask

  function automatic string resTag(logic [1:0] r);
    case (r)
      2'd0: return "R5";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R8";
    endcase
  endfunction

  // device model and cycle-by-cycle comparison against the reference timing
  always @(negedge clk) begin
    if (pendValid) begin
      rdValid = 1'b1;
      rdData  = devWord(validIdx);
      pendValid = 0;
      if (validIdx % 2 == 0)             nextReqCyc = cyc + 1;
      else if (validIdx == nReads - 1) begin doneCyc = cyc + 2; nextReqCyc = -1; end
      else if (validIdx == nReads - 3)   nextReqCyc = cyc + 2;
      else                               nextReqCyc = cyc + 2 + gapV;
    end else begin
      rdValid = 1'b0;
    end
    if (rdReq && rstN) begin
      chk(readIdx < nReads, "R2", "read count bound", readIdx, nReads);
      chk(cyc == nextReqCyc, "R4", "request cycle", cyc, nextReqCyc);
      pendValid = 1;
      validIdx  = readIdx;
      readIdx++;
    end
    if (doneOut && rstN) begin
      doneSeen = 1;
      chk(cyc == doneCyc, "R9", "done cycle", cyc, doneCyc);
      chk(readIdx == nReads, "R2", "reads taken", readIdx, nReads);
      chk(resultOut == expRes, resTag(expRes), "result", resultOut, expRes);
      chk(laneTmoOut == expFlags, "R6", "lane flags", laneTmoOut, expFlags);
      for (int i = 0; i < 4; i++)
        chk(dbgWords[i*W +: W] == expDbg[i], "R10", "debug word", dbgWords[i*W +: W], expDbg[i]);
    end
  end

  task automatic runOp(bit midStart);
    buildModel();
    @(negedge clk);
    startIn = 1'b1; expectIn = expW; limitIn = TMR_W'(limitV); gapIn = GAP_W'(gapV);
    readIdx = 0; doneSeen = 0; nextReqCyc = cyc + 1; doneCyc = -1;
    @(negedge clk);
    startIn = 1'b0;
    if (midStart) begin
      repeat (5) @(negedge clk);
      chk(busy == 1'b1, "R1", "busy mid-run", busy, 1);
      startIn = 1'b1; expectIn = '0; limitIn = '0;
      @(negedge clk);
      startIn = 1'b0; expectIn = expW;
    end
    for (int t = 0; t < 5000 && !doneSeen; t++) @(negedge clk);
    chk(doneSeen, "R9", "completion seen", doneSeen, 1);
    @(negedge clk);
    chk(doneOut == 1'b0 && busy == 1'b0, "R9", "done pulse ends, idle", {doneOut, busy}, 0);
    chk(resultOut == expRes, "R9", "result held", resultOut, expRes);
  endtask

  task automatic setScn(logic [W-1:0] e, logic [W-1:0] s, int br, logic [LANES-1:0] tg,
                        logic [LANES-1:0] b5, int lim, int gp, int oi, logic [W-1:0] ov);
    expW = e; settleW = s; busyReads = br; togL = tg; b5L = b5;
    limitV = lim; gapV = gp; ovrIdx = oi; ovrVal = ov;
  endtask

  bit finished = 0;
  initial begin
    #(20ns * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    nReads = 0; nextReqCyc = -1; doneCyc = -1; readIdx = 0; validIdx = 0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && rdReq == 0 && doneOut == 0 && resultOut == 0, "R1", "reset state",
        {busy, rdReq, doneOut, resultOut}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3: program, bit 5 set while busy must not stop polling; pass
    setScn(16'h3C5A, 16'h3C5A, 4, 2'b11, 2'b11, BIG_LIMIT, 0, -1, '0);
    runOp(0);
    chk(readIdx == 8, "R3", "bit5 ignored, reads", readIdx, 8);
    chk(resultOut == 2'd0, "R3", "pass despite bit5", resultOut, 0);

    // R1/R4: erase to all ones, gap 3, start ignored mid-run
    setScn(16'hFFFF, 16'hFFFF, 5, 2'b01, 2'b00, BIG_LIMIT, 3, -1, '0);
    runOp(1);
    chk(resultOut == 2'd0, "R1", "mid-run start ignored", resultOut, 0);

    // R6: limit 0, lane0 toggles with bit5 -> device timeout, lane1 bit5 masked
    setScn(16'h5555, 16'h5555, 1000, 2'b01, 2'b11, 0, 2, -1, '0);
    runOp(0);
    chk(laneTmoOut == 2'b01, "R6", "masked lane flags", laneTmoOut, 2'b01);

    // R7: bit5 only in a non-toggling lane -> controller timeout
    setScn(16'h5555, 16'h5555, 1000, 2'b10, 2'b01, 0, 0, -1, '0);
    runOp(0);
    chk(resultOut == 2'd2, "R7", "masked bit5 ignored", resultOut, 2);

    // R7: all lanes toggle, no bit5
    setScn(16'hA0A0, 16'hA0A0, 1000, 2'b11, 2'b00, 0, 1, -1, '0);
    runOp(0);

    // R8: settles to wrong value without timeout
    setScn(16'h1235, 16'h1234, 2, 2'b11, 2'b00, BIG_LIMIT, 2, -1, '0);
    runOp(0);
    chk(resultOut == 2'd3, "R8", "wrong final value", resultOut, 3);

    // R5/R8: second closing read differs
    setScn(16'h0F0F, 16'h0F0F, 2, 2'b11, 2'b00, BIG_LIMIT, 0, 5, 16'h0F0E);
    runOp(0);
    chk(resultOut == 2'd3, "R5", "both closing reads required (2nd)", resultOut, 3);

    // R5/R8: first closing read differs
    setScn(16'h0F0F, 16'h0F0F, 2, 2'b11, 2'b00, BIG_LIMIT, 0, 4, 16'h0F0E);
    runOp(0);
    chk(resultOut == 2'd3, "R5", "both closing reads required (1st)", resultOut, 3);

    // R3: expired limit but not toggling -> still a pass
    setScn(16'h7E81, 16'h7E81, 0, 2'b11, 2'b11, 0, 0, -1, '0);
    runOp(0);
    chk(readIdx == 4, "R3", "no toggle at once stops", readIdx, 4);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule